// File: doc/BRIEF.md
# One-Hot-of-Five Link Deserializer

This block terminates a narrow link that carries a packet as a series of 2-bit flits. Each flit is one symbol on five wires, and exactly one wire is high for a valid symbol. Four of the wires carry the 2-bit values 0 to 3. The fifth wire marks the end of the packet. A sixth wire, driven by this block, acknowledges each symbol with a four-phase return-to-zero handshake. The block decides that a symbol is complete from the one-hot code alone. It needs no strobe and no setup of a data bus.

A packet leaves some leftover routing flits at the front. The block drops these and then packs the data flits into a 20-bit word, with the first data flit in the lowest bit pair. When the end-of-packet symbol arrives, the word is offered to a local output adapter through a request/acknowledge pair. The link is held until the adapter accepts the word. Malformed symbols and wrong packet lengths raise sticky flags that only reset clears. The block samples the link on its own clock and assumes the link wires are already synchronous to that clock.

Top module: `o5_link_deser`

## Requirements
- R1: Symbol decoding: `link_sym[i]` high alone, for i in 0..3, is a data flit with value i. `link_sym[4]` high alone is end of packet. All wires low is the spacer.
- R2: One cycle after the block samples a valid non-end data symbol in the idle phase, `link_ack` rises. It stays high while any symbol wire is high, and it falls one cycle after all five wires are sampled low.
- R3: The first DROP_FLITS (default 4) flits of a packet are acknowledged but do not enter the word.
- R4: The k-th data flit after the dropped ones (k = 0..9) is written to `out_word[2k+1:2k]`, so the first data flit lands in the lowest pair.
- R5: One cycle after end of packet is sampled, `out_req` rises with the assembled word. `out_req` and `out_word` stay unchanged until `out_ack` is sampled high.
- R6: The end-of-packet flit is not acknowledged while `out_req` is high. When `out_ack` is sampled, `out_req` falls and `link_ack` rises on the same edge. An end-of-packet symbol is not taken while `out_ack` is still high.
- R7: If more than one symbol wire is high in the idle phase, `err_symbol` is set and stays set until reset. The symbol is not acknowledged and does not change the word or the flit count.
- R8: If end of packet arrives after a number of data flits other than 10, `err_length` is set and stays set until reset. The word is still delivered: unwritten pairs read zero, and data flits beyond the tenth are dropped.
- R9: During and after reset, `link_ack`, `out_req`, `err_symbol` and `err_length` are low, and the flit count starts from zero.
- R10: After each delivery, the flit count and the word are cleared, so the next packet again drops its leading route flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_sym | input | 5 | One-hot symbol wires: [3:0] data values, [4] end of packet |
| link_ack | output | 1 | Four-phase acknowledge back to the link sender |
| out_req | output | 1 | Word-ready request to the output adapter |
| out_ack | input | 1 | Output adapter acknowledge |
| out_word | output | 20 | Assembled packet payload |
| err_symbol | output | 1 | Sticky flag: more than one symbol wire high |
| err_length | output | 1 | Sticky flag: data flit count at end of packet was not 10 |

## Verification
Random packets of full length, built from seeded random data values, test the bit-pair ordering and the dropping of the route flits. A wrong slot index, a wrong drop count, or a reversed order each give a different word. Random delays of the adapter acknowledge check that the end-of-packet flit stays unacknowledged and the word stays stable during the wait. A directed two-hot symbol checks that such a symbol is ignored: the next clean packet must assemble exactly as if the bad symbol had never come. Short and over-long packets check that the length flag is set, that the delivered word is zero-filled, and that extra flits are dropped.

// File: rtl/o5_link_pkg.sv
// Package: shared types for the one-hot-of-five link deserializer.
// Assumes a five-wire symbol bus: four data wires and one end-of-packet wire.
package o5_link_pkg;

    localparam int SYM_W  = 5;
    localparam int FLIT_W = 2;
    localparam int EOP_IX = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RTZ     = 2'd1,
        ST_DELIVER = 2'd2
    } link_state_t;

    typedef struct packed {
        logic              any;    // at least one wire high
        logic              multi;  // more than one wire high
        logic              eop;    // lone end-of-packet wire
        logic [FLIT_W-1:0] val;    // data value of a lone data wire
    } sym_info_t;

endpackage

// File: rtl/o5_sym_decode.sv
// Module: o5_sym_decode
// Purely combinational classifier of one five-wire symbol.
// Assumes the wires are sampled synchronously by the consumer.
module o5_sym_decode
    import o5_link_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output sym_info_t        info
);

    // Count high wires and encode the lone data wire position.
    always_comb begin
        int unsigned ones;
        ones = 0;
        info.val = '0;
        for (int i = 0; i < SYM_W; i++) begin
            if (sym[i]) ones = ones + 1;
        end
        for (int i = 0; i < EOP_IX; i++) begin
            if (sym[i]) info.val = FLIT_W'(i);
        end
        info.any   = (ones != 0);
        info.multi = (ones > 1);
        info.eop   = (ones == 1) && sym[EOP_IX];
    end

endmodule

// File: rtl/o5_word_asm.sv
// Module: o5_word_asm
// Counts the flits of a packet, drops the leading route flits and writes
// data flits into the word slot by slot, lowest pair first.
// Assumes take and clear never coincide (guaranteed by the handshake FSM).
module o5_word_asm
    import o5_link_pkg::*;
#(
    parameter int DROP_FLITS = 4,
    parameter int DATA_FLITS = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  logic [FLIT_W-1:0]            val,
    input  logic                         clear,
    output logic [DATA_FLITS*FLIT_W-1:0] word,
    output logic                         len_ok
);

    localparam int TOTAL = DROP_FLITS + DATA_FLITS;
    localparam int CNT_W = $clog2(TOTAL + 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TOTAL + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TOTAL);

    logic [CNT_W-1:0] cnt;

    // Flit counter: saturates one past a full packet so overlength is seen.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (take && cnt != CNT_SAT) cnt <= cnt + 1'b1;
    end

    // One register slot per data flit, written when the count points at it.
    for (genvar g = 0; g < DATA_FLITS; g++) begin : g_slot
        localparam logic [CNT_W-1:0] SLOT_AT = CNT_W'(DROP_FLITS + g);
        // Capture this slot's flit value, clear at delivery.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) word[g*FLIT_W +: FLIT_W] <= '0;
            else if (take && cnt == SLOT_AT) word[g*FLIT_W +: FLIT_W] <= val;
        end
    end

    assign len_ok = (cnt == CNT_FULL);

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clear) |=> $stable(word)) else $error("word changed without flit"); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word == '0) && !len_ok) else $error("clear did not empty word"); // R10

endmodule

// File: rtl/o5_link_fsm.sv
// Module: o5_link_fsm
// Four-phase handshake controller for the link and the output adapter,
// plus the sticky error flags. Assumes decoded symbol info is from sampled wires.
module o5_link_fsm
    import o5_link_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sym_info_t info,
    input  logic      len_ok,
    input  logic      out_ack,
    output logic      link_ack,
    output logic      out_req,
    output logic      take,
    output logic      clear,
    output logic      err_symbol,
    output logic      err_length
);

    link_state_t state;

    // Strobes to the assembler: accept a data flit, or empty after delivery.
    assign take  = (state == ST_IDLE) && info.any && !info.multi && !info.eop;
    assign clear = (state == ST_DELIVER) && out_ack;

    // Handshake sequencing and flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            link_ack   <= 1'b0;
            out_req    <= 1'b0;
            err_symbol <= 1'b0;
            err_length <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (info.multi) begin
                        err_symbol <= 1'b1;
                    end else if (info.eop) begin
                        if (!out_ack) begin
                            out_req <= 1'b1;
                            if (!len_ok) err_length <= 1'b1;
                            state <= ST_DELIVER;
                        end
                    end else if (info.any) begin
                        link_ack <= 1'b1;
                        state    <= ST_RTZ;
                    end
                end
                ST_RTZ: begin
                    if (!info.any) begin
                        link_ack <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                ST_DELIVER: begin
                    if (out_ack) begin
                        out_req  <= 1'b0;
                        link_ack <= 1'b1;
                        state    <= ST_RTZ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ack && info.any) |=> link_ack) else $error("ack dropped early"); // R2
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ack && !info.any) |=> !link_ack) else $error("ack stuck"); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |=> out_req) else $error("request withdrawn"); // R5
    AST_EOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> !link_ack) else $error("eop acked before adapter"); // R6
    AST_MULTI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && info.multi) |=> (!link_ack && err_symbol)) else $error("bad symbol acked"); // R7
    AST_SYM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_symbol |=> err_symbol) else $error("symbol flag cleared"); // R7
    AST_LEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_length |=> err_length) else $error("length flag cleared"); // R8

endmodule

// File: rtl/o5_link_deser.sv
// Module: o5_link_deser (top)
// Receives one-hot-of-five flits, drops leading route flits, builds the
// payload word and hands it to the output adapter on end of packet.
// Assumes link wires are synchronous to clk.
module o5_link_deser
    import o5_link_pkg::*;
#(
    parameter int DROP_FLITS = 4,
    parameter int DATA_FLITS = 10,
    localparam int WORD_W = DATA_FLITS * FLIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  link_sym,
    output logic              link_ack,
    output logic              out_req,
    input  logic              out_ack,
    output logic [WORD_W-1:0] out_word,
    output logic              err_symbol,
    output logic              err_length
);

    sym_info_t info;
    logic      take;
    logic      clear;
    logic      len_ok;

    o5_sym_decode u_dec (
        .sym  (link_sym),
        .info (info)
    );

    o5_word_asm #(
        .DROP_FLITS (DROP_FLITS),
        .DATA_FLITS (DATA_FLITS)
    ) u_asm (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .val    (info.val),
        .clear  (clear),
        .word   (out_word),
        .len_ok (len_ok)
    );

    o5_link_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .info       (info),
        .len_ok     (len_ok),
        .out_ack    (out_ack),
        .link_ack   (link_ack),
        .out_req    (out_req),
        .take       (take),
        .clear      (clear),
        .err_symbol (err_symbol),
        .err_length (err_length)
    );

endmodule

// File: tb/o5_link_deser_tb.sv
module o5_link_deser_tb;

    localparam int DROP = 4;
    localparam int NDAT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  link_sym = '0;
    logic        out_ack = 1'b0;
    logic        link_ack, out_req, err_symbol, err_length;
    logic [19:0] out_word;

    int n_tests = 0;
    int n_fail  = 0;
    int dvals[16];

    always #4 clk = ~clk;

    o5_link_deser u_dut (
        .clk(clk), .rst_n(rst_n), .link_sym(link_sym), .link_ack(link_ack),
        .out_req(out_req), .out_ack(out_ack), .out_word(out_word),
        .err_symbol(err_symbol), .err_length(err_length)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_word(input int n);
        logic [19:0] w = '0;
        for (int k = 0; k < n && k < NDAT; k++) w[2*k +: 2] = 2'(dvals[k]);
        return w;
    endfunction

    task automatic wait_for(input logic want, input int which);
        for (int i = 0; i < 40; i++) begin
            if ((which == 0 ? link_ack : out_req) === want) return;
            @(negedge clk);
        end
    endtask

    // Send one flit; for data flits verify the ack comes one cycle later (R2).
    task automatic send_data(input int v, input bit chk);
        @(negedge clk);
        link_sym = 5'(1 << v);
        @(negedge clk);
        if (chk) check("R2 ack rises after symbol", link_ack, 1'b1);
        wait_for(1'b1, 0);
        link_sym = '0;
        @(negedge clk);
        if (chk) check("R2 ack falls after spacer", link_ack, 1'b0);
        wait_for(1'b0, 0);
    endtask

    // Send end of packet, hold adapter ack for 'lag' cycles, return word.
    task automatic send_eop(input int lag, output logic [19:0] w);
        @(negedge clk);
        link_sym = 5'b10000;
        @(negedge clk);
        check("R5 request after eop", out_req, 1'b1);
        w = out_word;
        for (int i = 0; i < lag; i++) begin
            @(negedge clk);
            check("R6 eop unacked while pending", link_ack, 1'b0);
            check("R5 word stable while pending", out_word, w);
        end
        out_ack = 1'b1;
        @(negedge clk);
        check("R6 ack rises with adapter ack", link_ack, 1'b1);
        check("R6 request falls", out_req, 1'b0);
        link_sym = '0;
        out_ack = 1'b0;
        wait_for(1'b0, 0);
    endtask

    task automatic packet(input int ndata, input int lag, input bit chk, output logic [19:0] w);
        for (int r = 0; r < DROP; r++) send_data(int'($urandom_range(0, 3)), chk);
        for (int k = 0; k < ndata; k++) begin
            if (k < 16) dvals[k] = int'($urandom_range(0, 3));
            send_data(k < 16 ? dvals[k] : 0, chk);
        end
        send_eop(lag, w);
    endtask

    initial begin
        logic [19:0] w;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R9 ack low in reset", link_ack, 1'b0);
        check("R9 req low in reset", out_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 flags clear", {err_symbol, err_length}, 2'b00);

        // Directed: all data flits equal 3 then ascending pattern (R1, R4).
        for (int k = 0; k < NDAT; k++) dvals[k] = 3;
        for (int r = 0; r < DROP; r++) send_data(2, 1);
        for (int k = 0; k < NDAT; k++) send_data(3, 1);
        send_eop(0, w);
        check("R1 all-three word", w, 20'hFFFFF);
        for (int k = 0; k < NDAT; k++) dvals[k] = k % 4;
        for (int r = 0; r < DROP; r++) send_data(3, 0);
        for (int k = 0; k < NDAT; k++) send_data(dvals[k], 0);
        send_eop(1, w);
        check("R4 ascending pair order", w, exp_word(NDAT));

        // Random full packets (R3, R4, R10).
        for (int p = 0; p < 12; p++) begin
            packet(NDAT, int'($urandom_range(0, 4)), p < 2, w);
            check("R3 R4 random word", w, exp_word(NDAT));
        end
        check("R8 no length error on full packets", err_length, 1'b0);
        check("R7 no symbol error yet", err_symbol, 1'b0);

        // Two-hot symbol: flagged, not acked, no effect (R7).
        @(negedge clk);
        link_sym = 5'b00110;
        repeat (3) begin
            @(negedge clk);
            check("R7 two-hot not acked", link_ack, 1'b0);
        end
        check("R7 symbol flag set", err_symbol, 1'b1);
        link_sym = '0;
        packet(NDAT, 0, 0, w);
        check("R7 bad symbol left word untouched", w, exp_word(NDAT));
        check("R7 symbol flag sticky", err_symbol, 1'b1);
        check("R8 length fine after bad symbol", err_length, 1'b0);

        // Short packet: zero-filled, length flag (R8).
        packet(6, 0, 0, w);
        check("R8 short word zero filled", w, exp_word(6));
        check("R8 length flag on short", err_length, 1'b1);
        // Overlong packet: extra flits dropped (R8).
        packet(13, 0, 0, w);
        check("R8 overlong word", w, exp_word(13));
        // Next full packet restarts cleanly (R10).
        packet(NDAT, 2, 0, w);
        check("R10 fresh packet after errors", w, exp_word(NDAT));
        check("R8 length flag sticky", err_length, 1'b1);

        // EOP not taken while adapter ack still high (R6).
        @(negedge clk);
        out_ack = 1'b1;
        link_sym = 5'b10000;
        repeat (2) @(negedge clk);
        check("R6 eop held off by high out_ack", out_req, 1'b0);
        out_ack = 1'b0;
        @(negedge clk);
        check("R6 eop taken after out_ack low", out_req, 1'b1);
        check("R8 empty packet word", out_word, 20'h0);
        out_ack = 1'b1;
        @(negedge clk);
        link_sym = '0;
        out_ack = 1'b0;
        wait_for(1'b0, 0);

        // Reset mid-operation clears state (R9).
        send_data(1, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 flags cleared by reset", {err_symbol, err_length}, 2'b00);
        packet(NDAT, 0, 0, w);
        check("R9 counter restarted", w, exp_word(NDAT));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule